// File: doc/BRIEF.md
# Two-Channel Regulator Bring-Up Sequencer

This block controls power-up and power-down of a two-channel switching regulator controller. It watches two supply flags: power-on reset and under-voltage lockout. It also watches a per-channel enable. It requests the shared reference and waits until the reference reports ready. Each channel then gets its own settling window before its drivers are released. After that, the block moves a digital target-voltage code from zero to the programmed setpoint at a fixed slope per channel. The code counts in units of 0.1 mV. When a channel is disabled, or the supply drops below its lockout level, the target slopes back down. The block then reports the channel idle.

Each channel runs its own state machine with seven states:
- `CH_OFF`: idle, target zero.
- `CH_WAIT_REF`: reference requested, waiting for ready.
- `CH_MASK`: settling window.
- `CH_RAMP`: switching, target moving.
- `CH_HOLD`: switching, target at setpoint.
- `CH_SOFTOFF`: disabled, target falling with switching kept.
- `CH_DRAIN`: lockout, target falling with switching stopped.

The transitions are:
- `CH_OFF`→`CH_WAIT_REF` on enable with supply good.
- `CH_WAIT_REF`→`CH_MASK` on reference ready.
- `CH_MASK`→`CH_RAMP` when the window expires.
- `CH_RAMP`→`CH_HOLD` on reaching the setpoint.
- `CH_HOLD`→`CH_RAMP` when the setpoint changes.
- `CH_RAMP`/`CH_HOLD`→`CH_SOFTOFF` on enable low.
- `CH_RAMP`/`CH_HOLD`/`CH_SOFTOFF`→`CH_DRAIN` on lockout.
- `CH_SOFTOFF`/`CH_DRAIN`→`CH_OFF` when the target would fall below the floor.
- `CH_WAIT_REF`/`CH_MASK`→`CH_OFF` on enable low or lockout.
- Any state→`CH_OFF` while power-on reset is low.

The block has a time base of one tick per microsecond, made from `TICK_DIV` clocks. Target positions carry `FRAC_W` fractional bits, so a slope such as 6.5 codes per tick is exact on average.

Top module: `vreg_bringup`

## Requirements
- R1: While `por_ok` is low, from the next clock edge on, both channels are in `CH_OFF`: `sw_en` = 0, both targets = 0, `off_done` = 2'b11, and `ref_en` = 0, whatever the enables do.
- R2: `ref_en` is registered one edge after its inputs. It is 1 only when `por_ok` and `uvlo_ok` are both 1, and at the same time either some `chan_en` bit is 1 or some channel is not yet in `CH_OFF`. Whenever any `sw_en` bit is 1, `ref_en` is 1.
- R3: An enabled channel stays in `CH_WAIT_REF`, with its `sw_en` bit 0 and its `off_done` bit 0, for as long as `ref_ready` is low.
- R4: A channel's `sw_en` bit rises exactly `MASK_TICKS*TICK_DIV` clock edges after the edge that moves it from `CH_WAIT_REF` to `CH_MASK`. That move happens on the first edge at which `ref_ready` is seen high.
- R5: A channel enabled while the other one is already switching goes through its own full settling window. It starts switching `2 + MASK_TICKS*TICK_DIV` edges after its enable is applied. The running channel's `sw_en` and target are not disturbed.
- R6: Channel 0 target moves by `SLEW0_Q/2^FRAC_W` codes per tick, which is 13 by default. The first step comes one tick after switching starts. A ramp from 0 to 10500 (1.05 V) arrives in exactly 808 ticks.
- R7: Channel 1 moves by `SLEW1_Q/2^FRAC_W` codes per tick, which is 6.5 by default, with the half code kept internally. The reported code is the position rounded down: 6 after one tick and 13 after two. A ramp from 0 to 10500 takes exactly 1616 ticks.
- R8: In `CH_HOLD` the target equals the setpoint. A later change of setpoint sends the channel back to `CH_RAMP`, which slopes the target to the new value at the same rate, up or down.
- R9: When a channel's enable falls, its `sw_en` stays 1 and its target falls by its slope per tick. The tick phase restarts at the falling edge. On the tick where the next value would drop below `FLOOR_CODE` (1000, 0.1 V), the target becomes 0 and `off_done` rises. From 10500, channel 0 does this after 731 ticks.
- R10: When `uvlo_ok` falls, both `sw_en` bits are 0 from the next edge. Targets still slope down at their rates, with the tick phase restarted, and reach 0 as in R9. From 10500, channel 1 gets there after 1462 ticks.
- R11: While `uvlo_ok` is low, raised enables are ignored. Both channels stay in `CH_OFF` with `off_done` = 2'b11 and `ref_en` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| por_ok | input | 1 | Supply above power-on-reset level |
| uvlo_ok | input | 1 | Supply above lockout level |
| ref_ready | input | 1 | Reference reports regulation |
| chan_en | input | 2 | Per-channel enable, bit 0 is channel 0 |
| setpoint0 | input | CODE_W | Channel 0 setpoint, 0.1 mV per code |
| setpoint1 | input | CODE_W | Channel 1 setpoint, 0.1 mV per code |
| ref_en | output | 1 | Power request to the reference |
| sw_en | output | 2 | Per-channel driver release |
| target0 | output | CODE_W | Channel 0 target code |
| target1 | output | CODE_W | Channel 1 target code |
| off_done | output | 2 | Channel is idle with target at zero |

## Verification
The bench builds the block with `TICK_DIV` = 4, so one microsecond tick is four clocks. `MASK_TICKS` stays at 140, and the slopes stay at 26 and 13 half-codes with `FRAC_W` = 1. The whole 140-tick settling window, ramps of more than 1600 ticks to 1.05 V, and complete soft stops therefore fit in a short run. Each can be checked to the exact clock edge.

// File: rtl/vrb_pkg.sv
`timescale 1ns/1ps
package vrb_pkg;

    typedef enum logic [2:0] {
        CH_OFF      = 3'd0,
        CH_WAIT_REF = 3'd1,
        CH_MASK     = 3'd2,
        CH_RAMP     = 3'd3,
        CH_HOLD     = 3'd4,
        CH_SOFTOFF  = 3'd5,
        CH_DRAIN    = 3'd6
    } ch_state_e;

endpackage

// File: rtl/vrb_tick.sv
`timescale 1ns/1ps
module vrb_tick #(
    parameter int DIV = 250
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic tick
);

    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr || !run || cnt_q == LAST) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign tick = run && (cnt_q == LAST);

endmodule

// File: rtl/vrb_ramp.sv
`timescale 1ns/1ps
module vrb_ramp #(
    parameter int CODE_W     = 14,
    parameter int FRAC_W     = 1,
    parameter int SLEW_Q     = 26,
    parameter int FLOOR_CODE = 1000
) (
    input  logic [CODE_W+FRAC_W-1:0] pos,
    input  logic [CODE_W-1:0]        setpoint,
    output logic [CODE_W+FRAC_W-1:0] toward,
    output logic                     arrived,
    output logic                     at_sp,
    output logic [CODE_W+FRAC_W-1:0] down,
    output logic                     below
);

    localparam int QW = CODE_W + FRAC_W;
    localparam int EW = QW + 1;
    localparam logic [EW-1:0] SLEW_E  = EW'(SLEW_Q);
    localparam logic [EW-1:0] FLOOR_E = EW'(FLOOR_CODE) << FRAC_W;

    logic [EW-1:0] pos_e;
    logic [EW-1:0] sp_e;
    logic [EW-1:0] gap_e;

    assign pos_e = EW'(pos);
    assign sp_e  = EW'(setpoint) << FRAC_W;

    always_comb begin
        at_sp = (pos_e == sp_e);
        if (pos_e < sp_e) begin
            gap_e   = sp_e - pos_e;
            arrived = (gap_e <= SLEW_E);
            toward  = arrived ? QW'(sp_e) : QW'(pos_e + SLEW_E);
        end else begin
            gap_e   = pos_e - sp_e;
            arrived = (gap_e <= SLEW_E);
            toward  = arrived ? QW'(sp_e) : QW'(pos_e - SLEW_E);
        end
        below = (pos_e < FLOOR_E + SLEW_E);
        down  = QW'(pos_e - SLEW_E);
    end

endmodule

// File: rtl/vrb_chan.sv
`timescale 1ns/1ps
module vrb_chan
    import vrb_pkg::*;
#(
    parameter int CODE_W     = 14,
    parameter int FRAC_W     = 1,
    parameter int SLEW_Q     = 26,
    parameter int TICK_DIV   = 250,
    parameter int MASK_TICKS = 140,
    parameter int FLOOR_CODE = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_ok,
    input  logic              uvlo_ok,
    input  logic              ref_ready,
    input  logic              en,
    input  logic [CODE_W-1:0] setpoint,
    output logic              sw_en,
    output logic [CODE_W-1:0] target,
    output logic              done
);

    localparam int QW  = CODE_W + FRAC_W;
    localparam int MCW = (MASK_TICKS > 1) ? $clog2(MASK_TICKS) : 1;
    localparam logic [MCW-1:0] MASK_LAST = MCW'(MASK_TICKS - 1);
    localparam logic [CODE_W-1:0] MAX_STEP = CODE_W'((SLEW_Q >> FRAC_W) + 1);

    ch_state_e       state_q, state_d;
    logic [QW-1:0]   pos_q, pos_d;
    logic [MCW-1:0]  mask_q, mask_d;

    logic            tick;
    logic            tick_run;
    logic            tick_clr;
    logic [QW-1:0]   toward;
    logic [QW-1:0]   down;
    logic            arrived;
    logic            at_sp;
    logic            below;

    vrb_tick #(.DIV(TICK_DIV)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tick_clr),
        .run   (tick_run),
        .tick  (tick)
    );

    vrb_ramp #(
        .CODE_W     (CODE_W),
        .FRAC_W     (FRAC_W),
        .SLEW_Q     (SLEW_Q),
        .FLOOR_CODE (FLOOR_CODE)
    ) u_ramp (
        .pos      (pos_q),
        .setpoint (setpoint),
        .toward   (toward),
        .arrived  (arrived),
        .at_sp    (at_sp),
        .down     (down),
        .below    (below)
    );

    assign tick_run = (state_q != CH_OFF) && (state_q != CH_WAIT_REF);
    assign tick_clr = (state_d != state_q) &&
                      (state_d == CH_MASK || state_d == CH_SOFTOFF || state_d == CH_DRAIN);

    // next state and datapath
    always_comb begin
        state_d = state_q;
        pos_d   = pos_q;
        mask_d  = mask_q;
        if (!por_ok) begin
            state_d = CH_OFF;
            pos_d   = '0;
            mask_d  = '0;
        end else begin
            unique case (state_q)
                CH_OFF: begin
                    pos_d = '0;
                    if (en && uvlo_ok) state_d = CH_WAIT_REF;
                end
                CH_WAIT_REF: begin
                    if (!en || !uvlo_ok) begin
                        state_d = CH_OFF;
                    end else if (ref_ready) begin
                        state_d = CH_MASK;
                        mask_d  = '0;
                    end
                end
                CH_MASK: begin
                    if (!en || !uvlo_ok) begin
                        state_d = CH_OFF;
                        mask_d  = '0;
                    end else if (tick) begin
                        if (mask_q == MASK_LAST) begin
                            state_d = CH_RAMP;
                            mask_d  = '0;
                        end else begin
                            mask_d = mask_q + 1'b1;
                        end
                    end
                end
                CH_RAMP: begin
                    if (!uvlo_ok) begin
                        state_d = CH_DRAIN;
                    end else if (!en) begin
                        state_d = CH_SOFTOFF;
                    end else if (tick) begin
                        pos_d = toward;
                        if (arrived) state_d = CH_HOLD;
                    end
                end
                CH_HOLD: begin
                    if (!uvlo_ok)   state_d = CH_DRAIN;
                    else if (!en)   state_d = CH_SOFTOFF;
                    else if (!at_sp) state_d = CH_RAMP;
                end
                CH_SOFTOFF, CH_DRAIN: begin
                    if (state_q == CH_SOFTOFF && !uvlo_ok) begin
                        state_d = CH_DRAIN;
                    end else if (tick) begin
                        if (below) begin
                            state_d = CH_OFF;
                            pos_d   = '0;
                        end else begin
                            pos_d = down;
                        end
                    end
                end
                default: begin
                    state_d = CH_OFF;
                    pos_d   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CH_OFF;
            pos_q   <= '0;
            mask_q  <= '0;
        end else begin
            state_q <= state_d;
            pos_q   <= pos_d;
            mask_q  <= mask_d;
        end
    end

    // outputs
    always_comb begin
        sw_en = 1'b0;
        done  = 1'b0;
        unique case (state_q)
            CH_OFF:                          done  = 1'b1;
            CH_RAMP, CH_HOLD, CH_SOFTOFF:    sw_en = 1'b1;
            default: ;
        endcase
    end

    assign target = pos_q[QW-1:FRAC_W];

    // R1: power-on reset low forces the idle state
    a_r1_por_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !por_ok |=> (done && !sw_en && target == '0));

    // R10: lockout stops switching at the next edge
    a_r10_uvlo_stop: assert property (@(posedge clk) disable iff (!rst_n)
        !uvlo_ok |=> !sw_en);

    // R11: an idle channel stays idle under lockout
    a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !uvlo_ok) |=> done);

    // R4: switching starts only after the last settling tick
    a_r4_mask_full: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sw_en) |-> ($past(mask_q) == MASK_LAST));

    // R6, R7: the target never jumps by more than one slope step, except to zero
    a_r6_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (target != '0) |->
            (((target >= $past(target)) ? (target - $past(target))
                                        : ($past(target) - target)) <= MAX_STEP));

endmodule

// File: rtl/vreg_bringup.sv
`timescale 1ns/1ps
module vreg_bringup #(
    parameter int CODE_W     = 14,
    parameter int FRAC_W     = 1,
    parameter int TICK_DIV   = 250,
    parameter int MASK_TICKS = 140,
    parameter int SLEW0_Q    = 26,
    parameter int SLEW1_Q    = 13,
    parameter int FLOOR_CODE = 1000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_ok,
    input  logic              uvlo_ok,
    input  logic              ref_ready,
    input  logic [1:0]        chan_en,
    input  logic [CODE_W-1:0] setpoint0,
    input  logic [CODE_W-1:0] setpoint1,
    output logic              ref_en,
    output logic [1:0]        sw_en,
    output logic [CODE_W-1:0] target0,
    output logic [CODE_W-1:0] target1,
    output logic [1:0]        off_done
);

    localparam int NCH = 2;

    logic [CODE_W-1:0] sp_arr  [NCH];
    logic [CODE_W-1:0] tgt_arr [NCH];

    assign sp_arr[0] = setpoint0;
    assign sp_arr[1] = setpoint1;
    assign target0   = tgt_arr[0];
    assign target1   = tgt_arr[1];

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        localparam int SLEW = (g == 0) ? SLEW0_Q : SLEW1_Q;
        vrb_chan #(
            .CODE_W     (CODE_W),
            .FRAC_W     (FRAC_W),
            .SLEW_Q     (SLEW),
            .TICK_DIV   (TICK_DIV),
            .MASK_TICKS (MASK_TICKS),
            .FLOOR_CODE (FLOOR_CODE)
        ) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .por_ok    (por_ok),
            .uvlo_ok   (uvlo_ok),
            .ref_ready (ref_ready),
            .en        (chan_en[g]),
            .setpoint  (sp_arr[g]),
            .sw_en     (sw_en[g]),
            .target    (tgt_arr[g]),
            .done      (off_done[g])
        );
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ref_en <= 1'b0;
        end else begin
            ref_en <= por_ok && uvlo_ok && ((|chan_en) || !(&off_done));
        end
    end

    // R2: no channel switches without the reference requested
    a_r2_sw_needs_ref: assert property (@(posedge clk) disable iff (!rst_n)
        (|sw_en) |-> ref_en);

endmodule

// File: tb/test_vreg_bringup.sv
`timescale 1ns/1ps
module test_vreg_bringup;

    localparam int CW  = 14;
    localparam int DIV = 4;
    localparam int MT  = 140;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          por_ok;
    logic          uvlo_ok;
    logic          ref_ready;
    logic [1:0]    chan_en;
    logic [CW-1:0] setpoint0;
    logic [CW-1:0] setpoint1;
    logic          ref_en;
    logic [1:0]    sw_en;
    logic [CW-1:0] target0;
    logic [CW-1:0] target1;
    logic [1:0]    off_done;

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    vreg_bringup #(
        .CODE_W     (CW),
        .FRAC_W     (1),
        .TICK_DIV   (DIV),
        .MASK_TICKS (MT),
        .SLEW0_Q    (26),
        .SLEW1_Q    (13),
        .FLOOR_CODE (1000)
    ) i_vreg_bringup (
        .clk       (clk),
        .rst_n     (rst_n),
        .por_ok    (por_ok),
        .uvlo_ok   (uvlo_ok),
        .ref_ready (ref_ready),
        .chan_en   (chan_en),
        .setpoint0 (setpoint0),
        .setpoint1 (setpoint1),
        .ref_en    (ref_en),
        .sw_en     (sw_en),
        .target0   (target0),
        .target1   (target1),
        .off_done  (off_done)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int tgt(input int ch);
        return (ch == 0) ? int'(target0) : int'(target1);
    endfunction

    task automatic t_reset();
        chk("R1 reset ref_en", int'(ref_en), 0);
        chk("R1 reset sw_en", int'(sw_en), 0);
        chk("R1 reset target0", int'(target0), 0);
        chk("R1 reset target1", int'(target1), 0);
        chk("R1 reset off_done", int'(off_done), 3);
    endtask

    task automatic t_uvlo_gate();
        uvlo_ok = 1'b0; ref_ready = 1'b1; chan_en = 2'b11;
        step(40);
        chk("R11 ref_en under lockout", int'(ref_en), 0);
        chk("R11 sw_en under lockout", int'(sw_en), 0);
        chk("R11 off_done under lockout", int'(off_done), 3);
        chan_en = 2'b00; uvlo_ok = 1'b1; ref_ready = 1'b0;
        step(3);
    endtask

    task automatic t_first_enable();
        int n;
        int first_n;
        int first_v;
        setpoint0 = CW'(10500);
        chan_en   = 2'b01;
        step(20);
        chk("R2 ref_en after enable", int'(ref_en), 1);
        chk("R3 no switching before ready", int'(sw_en[0]), 0);
        chk("R3 not idle while waiting", int'(off_done[0]), 0);
        ref_ready = 1'b1;
        n = 0;
        while (sw_en[0] !== 1'b1 && n < 2000) begin @(negedge clk); n++; end
        chk("R4 settling window edges", n, 1 + MT*DIV);
        n = 0; first_n = -1; first_v = -1;
        while (target0 != CW'(10500) && n < 20000) begin
            @(negedge clk); n++;
            if (first_n < 0 && target0 != '0) begin first_n = n; first_v = int'(target0); end
        end
        chk("R6 first step delay", first_n, DIV);
        chk("R6 first step size", first_v, 13);
        chk("R6 ramp to 1.05 V edges", n, 808*DIV);
        step(20);
        chk("R8 hold at setpoint", int'(target0), 10500);
        chk("R8 switching in hold", int'(sw_en[0]), 1);
    endtask

    task automatic t_retarget();
        setpoint0 = CW'(10526);
        step(3*DIV + 4);
        chk("R8 retarget up", int'(target0), 10526);
        setpoint0 = CW'(10500);
        step(3*DIV + 4);
        chk("R8 retarget down", int'(target0), 10500);
    endtask

    task automatic t_late();
        int n;
        int v1;
        int v2;
        setpoint1 = CW'(10500);
        chan_en   = 2'b11;
        n = 0;
        while (sw_en[1] !== 1'b1 && n < 2000) begin @(negedge clk); n++; end
        chk("R5 late channel window", n, 2 + MT*DIV);
        chk("R5 running channel switching", int'(sw_en[0]), 1);
        chk("R5 running channel target", int'(target0), 10500);
        n = 0; v1 = -1; v2 = -1;
        while (target1 != CW'(10500) && n < 20000) begin
            @(negedge clk); n++;
            if (n == DIV)   v1 = int'(target1);
            if (n == 2*DIV) v2 = int'(target1);
        end
        chk("R7 half step after one tick", v1, 6);
        chk("R7 after two ticks", v2, 13);
        chk("R7 ramp to 1.05 V edges", n, 1616*DIV);
    endtask

    task automatic t_soft_off();
        int n;
        int mid;
        int sw1;
        chan_en = 2'b10;
        n = 0; mid = -1; sw1 = -1;
        while (off_done[0] !== 1'b1 && n < 20000) begin
            @(negedge clk); n++;
            if (n == 1)       sw1 = int'(sw_en[0]);
            if (n == 1 + DIV) mid = tgt(0);
        end
        chk("R9 switching kept during soft stop", sw1, 1);
        chk("R9 first down step", mid, 10487);
        chk("R9 soft stop edges", n, 1 + 731*DIV);
        chk("R9 target zero when idle", int'(target0), 0);
        chk("R9 switching off when idle", int'(sw_en[0]), 0);
        chk("R2 ref_en kept for other channel", int'(ref_en), 1);
        chk("R9 other channel untouched", int'(target1), 10500);
    endtask

    task automatic t_uvlo_drop();
        int n;
        int sw_n1;
        int ref_n1;
        int mid;
        uvlo_ok = 1'b0;
        n = 0; sw_n1 = -1; ref_n1 = -1; mid = -1;
        while (off_done[1] !== 1'b1 && n < 20000) begin
            @(negedge clk); n++;
            if (n == 1) begin sw_n1 = int'(sw_en); ref_n1 = int'(ref_en); end
            if (n == 1 + 2*DIV) mid = tgt(1);
        end
        chk("R10 switching stops next edge", sw_n1, 0);
        chk("R2 ref_en drops with lockout", ref_n1, 0);
        chk("R10 target after two ticks", mid, 10487);
        chk("R10 drain edges", n, 1 + 1462*DIV);
        chk("R10 target zero", int'(target1), 0);
    endtask

    task automatic t_por();
        uvlo_ok = 1'b1; ref_ready = 1'b1; chan_en = 2'b11;
        step(2 + MT*DIV + 10*DIV);
        chk("R4 both channels switching", int'(sw_en), 3);
        por_ok = 1'b0;
        step(1);
        chk("R1 sw_en after por drop", int'(sw_en), 0);
        chk("R1 target0 after por drop", int'(target0), 0);
        chk("R1 target1 after por drop", int'(target1), 0);
        chk("R1 ref_en after por drop", int'(ref_en), 0);
        chk("R1 off_done after por drop", int'(off_done), 3);
        step(20);
        chk("R1 enables ignored without por", int'(sw_en), 0);
        por_ok = 1'b1; chan_en = 2'b00;
        step(3);
    endtask

    initial begin
        #(4ns * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; por_ok = 1'b1; uvlo_ok = 1'b1; ref_ready = 1'b0;
        chan_en = 2'b00; setpoint0 = '0; setpoint1 = '0;
        step(5);
        rst_n = 1'b1;
        step(2);
        t_reset();
        t_uvlo_gate();
        t_first_enable();
        t_retarget();
        t_late();
        t_soft_off();
        t_uvlo_drop();
        t_por();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule